// File: doc/BRIEF.md
# Store Drain Tracker

The store drain tracker is a small decode-stage block for an in-order pipeline in which stores may leave the pipe before the instruction that caused them is known to be safe. It keeps two counters on the decode side. One counts stores that decode has caused to be issued. The other counts completion pulses returned by memory. Decode takes a new fetch bundle only when the two counters agree and every downstream queue can accept a write. As a result, no instruction is decoded while any store is still in flight.

The block also holds execute's own store count. Execute adds one for each autoincrement store and one for each execute-stage store it commits. It adds two when it squashes an instruction whose early autoincrement store already went out, because the original write and the compensating undo write are both in flight. On a restart, the decode-side issued count is overwritten with execute's count, and the generation number advances. The block then discards any fetch bundle that carries an older generation tag instead of decoding it.

All counters wrap modulo their width. Equality therefore stays valid across the wrap. An underflow output goes high when the completed count has run ahead of the issued count.

Top module: `store_drain_tracker`

## Requirements
- R1: When a bundle is accepted and no restart occurs in that cycle, the issued count rises one clock later by the number of set flags among `dec_autoinc` and `dec_exstore` (0, 1 or 2). Without an accept and without a restart it holds.
- R2: Each cycle with `st_done` high raises the completed count by one on the next clock. This also happens in a cycle where a bundle is accepted, and both updates take effect.
- R3: `dec_accept` is high only in a cycle where all of the following hold: `bundle_valid` is high, `bundle_gen` equals `gen_cur`, every bit of `q_ready` is 1, and the issued count equals the completed count. `drained` shows that equality.
- R4: When the other accept conditions hold but `bundle_gen` differs from `gen_cur`, `dec_drop` is high and `dec_accept` is low. The two are never high together.
- R5: On `ex_restart`, the issued count is loaded with execute's store count, including execute's updates in that same cycle. The restart overrides any decode-side increment in that cycle.
- R6: Execute's store count rises by `ex_autoinc` plus `ex_exstore` when `ex_commit` is high. It rises by 2 when `ex_squash_early` is high. When both are high in one cycle, the sum applies.
- R7: Each `ex_restart` raises `gen_cur` by one, modulo 2^GEN_W, on the next clock.
- R8: All counts wrap modulo 2^CNT_W. `underflow` is high exactly when bit CNT_W-1 of (issued minus completed, modulo 2^CNT_W) is 1.
- R9: A synchronous active-high `rst` clears all three counts and `gen_cur` to zero, with `drained` high and `underflow` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bundle_valid | input | 1 | Fetch bundle present at decode |
| bundle_gen | input | GEN_W | Generation tag of the bundle |
| q_ready | input | NUM_Q | Per downstream queue: can take a write |
| dec_autoinc | input | 1 | Bundle needs an autoincrement store |
| dec_exstore | input | 1 | Bundle needs an execute-stage store |
| st_done | input | 1 | Store-complete pulse from memory |
| ex_commit | input | 1 | Execute commits an instruction |
| ex_autoinc | input | 1 | Committed instruction had an autoincrement store |
| ex_exstore | input | 1 | Committed instruction issues an execute-stage store |
| ex_squash_early | input | 1 | Execute squashes an instruction whose early store went out (undo issued) |
| ex_restart | input | 1 | Pipeline restart from execute |
| dec_accept | output | 1 | Decode takes the bundle this cycle |
| dec_drop | output | 1 | Decode discards a stale bundle this cycle |
| drained | output | 1 | Issued count equals completed count |
| issued_cnt | output | CNT_W | Decode-side issued store count |
| done_cnt | output | CNT_W | Completed store count |
| exec_cnt | output | CNT_W | Execute-side store count |
| gen_cur | output | GEN_W | Current generation number |
| underflow | output | 1 | Completed count ahead of issued count |

## Verification
`dec_accept` and `dec_drop` depend combinationally on the inputs of the same cycle, so the bench reads them one nanosecond after driving the inputs, before the next rising edge. The counts, `gen_cur`, `drained` and `underflow` all move on the rising edge that follows the stimulus. The bench therefore compares them at the next falling edge against a model that it advances on that same edge. Because every single-cycle step checks both groups, a result that arrives a cycle early or a cycle late shows up as a mismatch.

// File: rtl/sdt_pkg.sv
package sdt_pkg;

   // How the drained flag is produced.
   typedef enum logic [0:0] {
      DRAIN_COMB = 1'b0,   // compare the two count registers
      DRAIN_REG  = 1'b1    // register the compare of the next values
   } drain_impl_e;

   // Number of stores implied by a pair of store flags.
   function automatic logic [1:0] store_pair(input logic a, input logic b);
      return {1'b0, a} + {1'b0, b};
   endfunction

endpackage

// File: rtl/sdt_issue_ctr.sv
module sdt_issue_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             accept,
   input  logic             autoinc,
   input  logic             exstore,
   input  logic             restart,
   input  logic [CNT_W-1:0] load_val,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam int PAD_W = CNT_W - 2;

   logic [1:0] delta;

   always_comb begin
      delta = accept ? sdt_pkg::store_pair(autoinc, exstore) : 2'd0;
      if (restart)
         cnt_nxt = load_val;
      else
         cnt_nxt = cnt + {{PAD_W{1'b0}}, delta};
   end

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_nxt;
   end
endmodule

// File: rtl/sdt_done_ctr.sv
module sdt_done_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             pulse,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam int PAD_W = CNT_W - 1;

   assign cnt_nxt = cnt + {{PAD_W{1'b0}}, pulse};

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_nxt;
   end
endmodule

// File: rtl/sdt_exec_ctr.sv
module sdt_exec_ctr #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             commit,
   input  logic             autoinc,
   input  logic             exstore,
   input  logic             squash_early,
   output logic [CNT_W-1:0] cnt,
   output logic [CNT_W-1:0] cnt_nxt
);
   localparam int DELTA_W = 3;
   localparam int PAD_W   = CNT_W - DELTA_W;

   logic [DELTA_W-1:0] delta;

   always_comb begin
      delta = '0;
      // a squashed early store is in flight, plus its undo write
      if (squash_early) delta = delta + 3'd2;
      if (commit)       delta = delta + {1'b0, sdt_pkg::store_pair(autoinc, exstore)};
      cnt_nxt = cnt + {{PAD_W{1'b0}}, delta};
   end

   always_ff @(posedge clk) begin
      if (rst) cnt <= '0;
      else     cnt <= cnt_nxt;
   end
endmodule

// File: rtl/sdt_gen_tracker.sv
module sdt_gen_tracker #(
   parameter int GEN_W = 4
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             restart,
   input  logic [GEN_W-1:0] tag,
   output logic [GEN_W-1:0] gen,
   output logic             match
);
   localparam logic [GEN_W-1:0] ONE = GEN_W'(1);

   assign match = (tag == gen);

   always_ff @(posedge clk) begin
      if (rst)          gen <= '0;
      else if (restart) gen <= gen + ONE;
   end
endmodule

// File: rtl/store_drain_tracker.sv
module store_drain_tracker #(
   parameter int                  CNT_W      = 16,
   parameter int                  GEN_W      = 4,
   parameter int                  NUM_Q      = 3,
   parameter sdt_pkg::drain_impl_e DRAIN_IMPL = sdt_pkg::DRAIN_REG
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             bundle_valid,
   input  logic [GEN_W-1:0] bundle_gen,
   input  logic [NUM_Q-1:0] q_ready,
   input  logic             dec_autoinc,
   input  logic             dec_exstore,
   input  logic             st_done,
   input  logic             ex_commit,
   input  logic             ex_autoinc,
   input  logic             ex_exstore,
   input  logic             ex_squash_early,
   input  logic             ex_restart,
   output logic             dec_accept,
   output logic             dec_drop,
   output logic             drained,
   output logic [CNT_W-1:0] issued_cnt,
   output logic [CNT_W-1:0] done_cnt,
   output logic [CNT_W-1:0] exec_cnt,
   output logic [GEN_W-1:0] gen_cur,
   output logic             underflow
);
   localparam int SIGN_BIT = CNT_W - 1;

   if (CNT_W < 4) begin : g_bad_cnt
      $error("store_drain_tracker: CNT_W must be at least 4");
   end
   if (GEN_W < 1) begin : g_bad_gen
      $error("store_drain_tracker: GEN_W must be at least 1");
   end
   if (NUM_Q < 1) begin : g_bad_q
      $error("store_drain_tracker: NUM_Q must be at least 1");
   end

   logic [CNT_W-1:0] iss_nxt, done_nxt, exec_nxt, outstanding;
   logic             gen_match, gate;

   sdt_exec_ctr #(.CNT_W(CNT_W)) u_exec (
      .clk(clk), .rst(rst), .commit(ex_commit), .autoinc(ex_autoinc),
      .exstore(ex_exstore), .squash_early(ex_squash_early),
      .cnt(exec_cnt), .cnt_nxt(exec_nxt)
   );

   sdt_issue_ctr #(.CNT_W(CNT_W)) u_issue (
      .clk(clk), .rst(rst), .accept(dec_accept), .autoinc(dec_autoinc),
      .exstore(dec_exstore), .restart(ex_restart), .load_val(exec_nxt),
      .cnt(issued_cnt), .cnt_nxt(iss_nxt)
   );

   sdt_done_ctr #(.CNT_W(CNT_W)) u_done (
      .clk(clk), .rst(rst), .pulse(st_done),
      .cnt(done_cnt), .cnt_nxt(done_nxt)
   );

   sdt_gen_tracker #(.GEN_W(GEN_W)) u_gen (
      .clk(clk), .rst(rst), .restart(ex_restart), .tag(bundle_gen),
      .gen(gen_cur), .match(gen_match)
   );

   if (DRAIN_IMPL == sdt_pkg::DRAIN_REG) begin : g_drain_reg
      logic drained_q;
      always_ff @(posedge clk) begin
         if (rst) drained_q <= 1'b1;
         else     drained_q <= (iss_nxt == done_nxt);
      end
      assign drained = drained_q;
   end else begin : g_drain_comb
      assign drained = (issued_cnt == done_cnt);
   end

   assign gate        = bundle_valid & drained & (&q_ready);
   assign dec_accept  = gate & gen_match;
   assign dec_drop    = gate & ~gen_match;

   assign outstanding = issued_cnt - done_cnt;
   assign underflow   = outstanding[SIGN_BIT];
endmodule

// File: rtl/sdt_tracker_chk.sv
module sdt_tracker_chk #(
   parameter int CNT_W = 16,
   parameter int GEN_W = 4,
   parameter int NUM_Q = 3
) (
   input logic             clk,
   input logic             rst,
   input logic             bundle_valid,
   input logic [GEN_W-1:0] bundle_gen,
   input logic [NUM_Q-1:0] q_ready,
   input logic             dec_autoinc,
   input logic             dec_exstore,
   input logic             st_done,
   input logic             ex_commit,
   input logic             ex_squash_early,
   input logic             ex_restart,
   input logic             dec_accept,
   input logic             dec_drop,
   input logic             drained,
   input logic [CNT_W-1:0] issued_cnt,
   input logic [CNT_W-1:0] done_cnt,
   input logic [CNT_W-1:0] exec_cnt,
   input logic [GEN_W-1:0] gen_cur
);
   // R1
   issue_step_chk: assert property (@(posedge clk) disable iff (rst)
      dec_accept && !ex_restart |=>
      issued_cnt == CNT_W'($past(issued_cnt) + $past(dec_autoinc) + $past(dec_exstore)));

   // R1
   issue_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !dec_accept && !ex_restart |=> $stable(issued_cnt));

   // R2
   done_step_chk: assert property (@(posedge clk) disable iff (rst)
      st_done |=> done_cnt == CNT_W'($past(done_cnt) + 1));

   // R2
   done_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !st_done |=> $stable(done_cnt));

   // R3
   accept_gate_chk: assert property (@(posedge clk) disable iff (rst)
      dec_accept |-> bundle_valid && drained && (&q_ready) && (bundle_gen == gen_cur)
                      && (issued_cnt == done_cnt));

   // R4
   accept_drop_excl_chk: assert property (@(posedge clk) disable iff (rst)
      $onehot0({dec_accept, dec_drop}));

   // R5
   restart_sync_chk: assert property (@(posedge clk) disable iff (rst)
      ex_restart |=> issued_cnt == exec_cnt);

   // R6
   squash_double_chk: assert property (@(posedge clk) disable iff (rst)
      ex_squash_early && !ex_commit |=> exec_cnt == CNT_W'($past(exec_cnt) + 2));

   // R7
   gen_step_chk: assert property (@(posedge clk) disable iff (rst)
      ex_restart |=> gen_cur == GEN_W'($past(gen_cur) + 1));

   // R9
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> issued_cnt == '0 && done_cnt == '0 && exec_cnt == '0 && gen_cur == '0 && drained);
endmodule

bind store_drain_tracker sdt_tracker_chk #(
   .CNT_W(CNT_W), .GEN_W(GEN_W), .NUM_Q(NUM_Q)
) u_chk (
   .clk(clk), .rst(rst), .bundle_valid(bundle_valid), .bundle_gen(bundle_gen),
   .q_ready(q_ready), .dec_autoinc(dec_autoinc), .dec_exstore(dec_exstore),
   .st_done(st_done), .ex_commit(ex_commit), .ex_squash_early(ex_squash_early),
   .ex_restart(ex_restart), .dec_accept(dec_accept), .dec_drop(dec_drop),
   .drained(drained), .issued_cnt(issued_cnt), .done_cnt(done_cnt),
   .exec_cnt(exec_cnt), .gen_cur(gen_cur)
);

// File: tb/store_drain_tracker_tb.sv
`timescale 1ns/1ps
module store_drain_tracker_tb;
   localparam int CNT_W = 8;
   localparam int GEN_W = 3;
   localparam int NUM_Q = 3;

   logic clk = 1'b0;
   logic rst = 1'b1;
   logic bundle_valid = 0, dec_autoinc = 0, dec_exstore = 0, st_done = 0;
   logic ex_commit = 0, ex_autoinc = 0, ex_exstore = 0, ex_squash_early = 0, ex_restart = 0;
   logic [GEN_W-1:0] bundle_gen = '0;
   logic [NUM_Q-1:0] q_ready = '1;
   logic dec_accept, dec_drop, drained, underflow;
   logic [CNT_W-1:0] issued_cnt, done_cnt, exec_cnt;
   logic [GEN_W-1:0] gen_cur;

   logic [CNT_W-1:0] m_iss = '0, m_done = '0, m_exec = '0;
   logic [GEN_W-1:0] m_gen = '0;
   int nchk = 0, nerr = 0;
   bit finished = 0;

   always #2.5 clk = ~clk;

   store_drain_tracker #(.CNT_W(CNT_W), .GEN_W(GEN_W), .NUM_Q(NUM_Q)) u_dut (
      .clk(clk), .rst(rst), .bundle_valid(bundle_valid), .bundle_gen(bundle_gen),
      .q_ready(q_ready), .dec_autoinc(dec_autoinc), .dec_exstore(dec_exstore),
      .st_done(st_done), .ex_commit(ex_commit), .ex_autoinc(ex_autoinc),
      .ex_exstore(ex_exstore), .ex_squash_early(ex_squash_early), .ex_restart(ex_restart),
      .dec_accept(dec_accept), .dec_drop(dec_drop), .drained(drained),
      .issued_cnt(issued_cnt), .done_cnt(done_cnt), .exec_cnt(exec_cnt),
      .gen_cur(gen_cur), .underflow(underflow)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      nchk++;
      if (!ok) begin
         nerr++;
         $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      bundle_valid = 0; dec_autoinc = 0; dec_exstore = 0; st_done = 0;
      ex_commit = 0; ex_autoinc = 0; ex_exstore = 0; ex_squash_early = 0;
      ex_restart = 0; q_ready = '1; bundle_gen = m_gen;
   endtask

   // One cycle: check same-cycle outputs, advance the model, check registered outputs.
   task automatic tick();
      logic drn, exp_acc, exp_drop;
      logic [CNT_W-1:0] e_nxt, diff;
      #1;
      drn      = (m_iss == m_done);
      exp_acc  = bundle_valid && drn && (&q_ready) && (bundle_gen == m_gen);
      exp_drop = bundle_valid && drn && (&q_ready) && (bundle_gen != m_gen);
      chk(dec_accept == exp_acc, "R3 dec_accept", int'(dec_accept), int'(exp_acc));
      chk(dec_drop == exp_drop, "R4 dec_drop", int'(dec_drop), int'(exp_drop));
      @(posedge clk);
      e_nxt = m_exec + (ex_squash_early ? 2 : 0) + (ex_commit ? int'(ex_autoinc) + int'(ex_exstore) : 0);
      if (ex_restart) m_iss = e_nxt;
      else if (exp_acc) m_iss = m_iss + int'(dec_autoinc) + int'(dec_exstore);
      m_done = m_done + int'(st_done);
      m_exec = e_nxt;
      if (ex_restart) m_gen = m_gen + 1;
      @(negedge clk);
      diff = m_iss - m_done;
      chk(issued_cnt == m_iss, "R1/R5 issued_cnt", int'(issued_cnt), int'(m_iss));
      chk(done_cnt == m_done, "R2 done_cnt", int'(done_cnt), int'(m_done));
      chk(exec_cnt == m_exec, "R6 exec_cnt", int'(exec_cnt), int'(m_exec));
      chk(gen_cur == m_gen, "R7 gen_cur", int'(gen_cur), int'(m_gen));
      chk(drained == (m_iss == m_done), "R3 drained", int'(drained), int'(m_iss == m_done));
      chk(underflow == diff[CNT_W-1], "R8 underflow", int'(underflow), int'(diff[CNT_W-1]));
   endtask

   task automatic drain_all();
      for (int k = 0; k < 600 && m_iss != m_done; k++) begin
         idle(); st_done = 1; tick();
      end
      idle();
   endtask

   task automatic t_reset();
      idle(); rst = 1; st_done = 1; ex_squash_early = 1; ex_restart = 1;
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst = 0; idle();
      m_iss = '0; m_done = '0; m_exec = '0; m_gen = '0;
      chk(issued_cnt == 0 && done_cnt == 0 && exec_cnt == 0, "R9 counts cleared",
          int'(issued_cnt) + int'(done_cnt) + int'(exec_cnt), 0);
      chk(gen_cur == 0, "R9 gen cleared", int'(gen_cur), 0);
      chk(drained == 1 && underflow == 0, "R9 drained/underflow", int'({drained, underflow}), 2);
   endtask

   // R1, R3: every flag pair, stall while stores are outstanding
   task automatic t_accept_flags();
      for (int f = 0; f < 4; f++) begin
         idle(); bundle_valid = 1; dec_autoinc = f[0]; dec_exstore = f[1]; tick();
         idle(); bundle_valid = 1; tick();        // stalled unless f == 0
         drain_all();
      end
   endtask

   // R3: any queue not ready blocks acceptance
   task automatic t_queue_block();
      for (int q = 0; q < NUM_Q; q++) begin
         idle(); bundle_valid = 1; dec_autoinc = 1; q_ready[q] = 1'b0; tick();
      end
      idle(); bundle_valid = 0; dec_autoinc = 1; tick();
   endtask

   // R6: execute counting
   task automatic t_exec();
      idle(); ex_commit = 1; ex_autoinc = 1; tick();
      idle(); ex_commit = 1; ex_exstore = 1; ex_autoinc = 1; tick();
      idle(); ex_squash_early = 1; tick();
      idle(); ex_squash_early = 1; ex_commit = 1; ex_exstore = 1; tick();
      idle(); ex_commit = 0; ex_autoinc = 1; ex_exstore = 1; tick();
   endtask

   // R5, R7, R4: restart resync and stale bundles
   task automatic t_restart();
      logic [GEN_W-1:0] old_gen;
      old_gen = m_gen;
      idle(); bundle_valid = 1; dec_autoinc = 1; dec_exstore = 1;
      ex_restart = 1; ex_commit = 1; ex_exstore = 1; tick();
      chk(issued_cnt == exec_cnt, "R5 issued resynced to exec", int'(issued_cnt), int'(exec_cnt));
      drain_all();
      idle(); bundle_valid = 1; bundle_gen = old_gen; dec_autoinc = 1; tick();   // stale: drop
      idle(); bundle_valid = 1; dec_exstore = 1; tick();                         // current: accept
      drain_all();
   endtask

   // R2: completion and acceptance in the same cycle
   task automatic t_simultaneous();
      idle(); bundle_valid = 1; dec_autoinc = 1; dec_exstore = 1; st_done = 1; tick();
      chk(int'(CNT_W'(issued_cnt - done_cnt)) == 1, "R2 both applied",
          int'(CNT_W'(issued_cnt - done_cnt)), 1);
      drain_all();
   endtask

   // R8: wrap of execute count carried into issued count
   task automatic t_wrap();
      for (int k = 0; k < 130; k++) begin
         idle(); ex_squash_early = 1; tick();
      end
      idle(); ex_restart = 1; tick();
      drain_all();
      idle(); bundle_valid = 1; dec_autoinc = 1; tick();
      drain_all();
   endtask

   // R8: completion with nothing outstanding
   task automatic t_underflow();
      idle(); st_done = 1; tick();
      chk(underflow == 1 && drained == 0, "R8 underflow raised", int'({underflow, drained}), 2);
      idle(); bundle_valid = 1; tick();
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_accept_flags();
      t_queue_block();
      t_exec();
      t_restart();
      t_simultaneous();
      t_wrap();
      t_underflow();
      t_reset();
      idle(); bundle_valid = 1; dec_exstore = 1; tick();
      drain_all();
      if (!finished) begin
         finished = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         finished = 1;
         nchk++; nerr++;
         $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end
endmodule